// File: doc/BRIEF.md
# Constant-Delay Time-Slot Interchanger

This block is a small TDM switch. Each slot strobe carries one 8-bit sample for every input stream, all for the same channel position. A frame holds `LAST_CH + 1` channel positions, and a frame-start flag marks position 0. The samples are written into one of three data banks, and the bank in use changes at every frame start.

For each output stream and channel position, a connection word decides what goes out:
- a sample taken from any input stream and channel of the bank filled two frames earlier, or
- a fixed message byte held in the word itself.

Because the read bank always trails the write bank by exactly two frames, the latency of a switched sample is two frames plus the difference between the output and input channel positions. That latency does not change with the order of the two positions, so the samples of one frame stay together.

Connection words are loaded and inspected through a plain 16-bit register port. The address is formed as {output stream[1:0], channel[6:0]}.

The input side has a valid/ready pair. `in_ready` rises one cycle after reset is released and stays high, so there is no back-pressure: a slot that is offered while ready is high is always taken. The output side only has a valid strobe. TDM slots cannot be stalled, so the consumer must take every slot in the cycle in which `out_valid` is high.

Top module: `tsi_cd_switch`

## Requirements
- R1: While reset is held and directly after it, `out_valid` is 0, `out_data` is 0, `reg_rdata` is 0 and `in_ready` is 0. Every connection word and every data bank sample is 0.
- R2: `in_ready` is 1 from the first cycle after reset onward. Each slot taken at a clock edge produces exactly one `out_valid` pulse in the next cycle. That pulse has `out_sof` set for a frame start, and `out_ch` gives the channel position. Position counts from 0 at a frame start and adds one per slot. Slots offered before the first frame start are dropped and produce no output.
- R3: A connection word with bit 0 = 0 switches a sample. Output slot n of frame F then carries the sample of input stream `word[13:9]`, channel `word[8:1]`, from frame F-2. This is a delay of 2 frames plus (n - m) channel times.
- R4: The shortest path is last input channel to output channel 0, which is 1 frame + 1 channel. The longest path is input channel 0 to the last output channel, which is 3 frames - 1 channel. Both follow the rule of R3.
- R5: A switched output slot in the first two frames after reset carries 0x00.
- R6: A connection word with bit 0 = 1 selects message mode. The slot then carries `word[10:3]` whatever arrives on the inputs.
- R7: In switched mode, a source stream number of `NIN` or more, or a source channel greater than `LAST_CH`, yields 0x00.
- R8: A write stores `reg_wdata[13:0]` at the addressed word. A read returns `{2'b00, word}` on `reg_rdata` one cycle after `reg_rd_en`, and holds it until the next read. Bit 14 (and 15) is neither stored nor able to change the output.
- R9: An address whose channel field exceeds `LAST_CH` is ignored by writes, and reading it returns 0.
- R10: A connection word written in one cycle governs every slot taken from the next cycle onward, including a slot later in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Slot offered on `in_data` |
| in_ready | output | 1 | High when slots are taken; constant 1 after reset |
| in_sof | input | 1 | Offered slot is channel position 0 of a new frame |
| in_data | input | 32 | One byte per input stream, stream s at bits [8s+7:8s] |
| out_valid | output | 1 | One-cycle strobe of an output slot |
| out_sof | output | 1 | Output slot is channel position 0 |
| out_ch | output | 5 | Channel position of the output slot |
| out_data | output | 32 | One byte per output stream, stream o at bits [8o+7:8o] |
| reg_wr_en | input | 1 | Write connection word |
| reg_rd_en | input | 1 | Read connection word |
| reg_addr | input | 9 | {output stream, channel} |
| reg_wdata | input | 16 | Word to write |
| reg_rdata | output | 16 | Word read, valid the cycle after `reg_rd_en` |

## Verification
- An output slot is due in the cycle after the edge that took the slot.
- Read data is due in the cycle after the edge that saw `reg_rd_en`.
- A connection write at one edge already governs a slot taken at the following edge.
- A switched sample reappears two frame starts later, at the position its connection word names.

The bench drives every input on the falling edge. It predicts each result from a frame-indexed history of the samples it sent and from its own copy of the connection words. It samples 1 ns after the rising edge at which that result is due, so even idle cycles are checked for a silent `out_valid`.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int CM_BITS = 14;
  localparam int NBANK   = 3;

  typedef logic [CM_BITS-1:0] cm_word_t;

  typedef struct packed {
    logic       msg_mode;
    logic [4:0] src_st;
    logic [7:0] src_ch;
    logic [7:0] msg_byte;
  } cm_dec_t;

  function automatic cm_dec_t cm_decode(cm_word_t w);
    cm_dec_t d;
    d.msg_mode = w[0];
    d.src_ch   = w[8:1];
    d.src_st   = w[13:9];
    d.msg_byte = w[10:3];
    return d;
  endfunction

  function automatic logic [1:0] bank_next(logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction
endpackage

// File: rtl/tsi_frame_ctr.sv
module tsi_frame_ctr
  import tsi_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            sof,
  output logic            accept,
  output logic [CH_W-1:0] cur_ch,
  output logic [1:0]      wr_bank,
  output logic [1:0]      rd_bank
);
  logic            running;
  logic [CH_W-1:0] ch_q;
  logic [1:0]      bank_q;

  // A slot is taken once the first frame start has been seen.
  assign accept  = go && (sof || running);
  assign cur_ch  = sof ? '0 : ch_q;
  assign wr_bank = sof ? bank_next(bank_q) : bank_q;
  // Read bank = bank written two frames before = one step ahead modulo 3.
  assign rd_bank = bank_next(wr_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      ch_q    <= '0;
      bank_q  <= 2'd2;
    end else if (accept) begin
      running <= 1'b1;
      ch_q    <= (cur_ch == CH_W'(NCH - 1)) ? '0 : cur_ch + 1'b1;
      bank_q  <= wr_bank;
    end
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NST = 4,
  parameter int NCH = 32,
  parameter int NRD = 4,
  localparam int ST_W = $clog2(NST),
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          wr_bank,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [NST*8-1:0]    wr_bytes,
  input  logic [1:0]          rd_bank,
  input  logic [NRD*ST_W-1:0] rd_st,
  input  logic [NRD*CH_W-1:0] rd_ch,
  output logic [NRD*8-1:0]    rd_bytes
);
  logic [7:0] mem [NBANK][NST][NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int s = 0; s < NST; s++)
          for (int c = 0; c < NCH; c++)
            mem[b][s][c] <= 8'd0;
    end else if (we) begin
      for (int s = 0; s < NST; s++)
        mem[wr_bank][s][wr_ch] <= wr_bytes[s*8 +: 8];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [ST_W-1:0] st_i;
    logic [CH_W-1:0] ch_i;
    assign st_i = rd_st[r*ST_W +: ST_W];
    assign ch_i = rd_ch[r*CH_W +: CH_W];
    assign rd_bytes[r*8 +: 8] = mem[rd_bank][st_i][ch_i];
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NOUT  = 4,
  parameter int NCH   = 32,
  parameter int CH_AW = 7,
  localparam int OUT_SW = $clog2(NOUT),
  localparam int CH_W   = $clog2(NCH),
  localparam int AW     = OUT_SW + CH_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [15:0]             wdata,
  output logic [15:0]             rdata,
  input  logic [CH_W-1:0]         lk_ch,
  output logic [NOUT*CM_BITS-1:0] lk_words
);
  cm_word_t cm [NOUT][NCH];

  logic [OUT_SW-1:0] a_st;
  logic [CH_AW-1:0]  a_ch;
  logic [CH_W-1:0]   a_idx;
  logic              a_ok;
  logic              unused_hi;

  assign a_st      = addr[AW-1:CH_AW];
  assign a_ch      = addr[CH_AW-1:0];
  assign a_idx     = CH_W'(a_ch);
  assign a_ok      = int'(a_ch) < NCH;
  assign unused_hi = ^wdata[15:CM_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < NOUT; o++)
        for (int c = 0; c < NCH; c++)
          cm[o][c] <= '0;
      rdata <= 16'd0;
    end else begin
      if (wr_en && a_ok)
        cm[a_st][a_idx] <= wdata[CM_BITS-1:0];
      if (rd_en)
        rdata <= a_ok ? {{(16-CM_BITS){1'b0}}, cm[a_st][a_idx]} : 16'd0;
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_lk
    assign lk_words[o*CM_BITS +: CM_BITS] = cm[o][lk_ch];
  end
endmodule

// File: rtl/tsi_cd_switch.sv
module tsi_cd_switch
  import tsi_pkg::*;
#(
  parameter int NIN     = 4,
  parameter int NOUT    = 4,
  parameter int LAST_CH = 31,
  parameter int CH_AW   = 7,
  localparam int NCH    = LAST_CH + 1,
  localparam int CH_W   = $clog2(NCH),
  localparam int IN_SW  = $clog2(NIN),
  localparam int OUT_SW = $clog2(NOUT),
  localparam int AW     = OUT_SW + CH_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [NIN*8-1:0]  in_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic [CH_W-1:0]   out_ch,
  output logic [NOUT*8-1:0] out_data,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata
);
  logic                     rdy_q;
  logic                     accept;
  logic [CH_W-1:0]          cur_ch;
  logic [1:0]               wr_bank;
  logic [1:0]               rd_bank;
  logic [NOUT*IN_SW-1:0]    rd_st_f;
  logic [NOUT*CH_W-1:0]     rd_ch_f;
  logic [NOUT*8-1:0]        rd_byte_f;
  logic [NOUT*CM_BITS-1:0]  lk_words;
  logic [NOUT*8-1:0]        nxt_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;

  tsi_frame_ctr #(.NCH(NCH)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (in_valid && rdy_q),
    .sof     (in_sof),
    .accept  (accept),
    .cur_ch  (cur_ch),
    .wr_bank (wr_bank),
    .rd_bank (rd_bank)
  );

  tsi_data_mem #(.NST(NIN), .NCH(NCH), .NRD(NOUT)) u_dmem (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (accept),
    .wr_bank  (wr_bank),
    .wr_ch    (cur_ch),
    .wr_bytes (in_data),
    .rd_bank  (rd_bank),
    .rd_st    (rd_st_f),
    .rd_ch    (rd_ch_f),
    .rd_bytes (rd_byte_f)
  );

  tsi_conn_mem #(.NOUT(NOUT), .NCH(NCH), .CH_AW(CH_AW)) u_cmem (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .lk_ch    (cur_ch),
    .lk_words (lk_words)
  );

  // Per output stream: decode the connection word and pick the slot byte.
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    cm_dec_t dec;
    logic    src_ok;
    always_comb begin
      dec    = cm_decode(lk_words[o*CM_BITS +: CM_BITS]);
      src_ok = (int'(dec.src_st) < NIN) && (int'(dec.src_ch) < NCH);
    end
    assign rd_st_f[o*IN_SW +: IN_SW] = IN_SW'(dec.src_st);
    assign rd_ch_f[o*CH_W +: CH_W]   = CH_W'(dec.src_ch);
    assign nxt_byte[o*8 +: 8] = dec.msg_mode ? dec.msg_byte
                              : (src_ok ? rd_byte_f[o*8 +: 8] : 8'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_sof  <= in_sof;
        out_ch   <= cur_ch;
        out_data <= nxt_byte;
      end
    end
  end
endmodule

// File: rtl/tsi_cd_checker.sv
module tsi_cd_checker #(
  parameter int NCH  = 32,
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_sof,
  input logic [CH_W-1:0] out_ch,
  input logic [15:0]     reg_rdata
);
  logic            seen;
  logic [CH_W-1:0] prev_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      prev_ch <= '0;
    end else if (out_valid) begin
      seen    <= 1'b1;
      prev_ch <= out_ch;
    end
  end

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));  // R2

  AST_SOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (out_ch == '0));  // R2

  AST_CH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof && seen) |->
      (out_ch == ((prev_ch == CH_W'(NCH - 1)) ? '0 : prev_ch + 1'b1)));  // R2

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);  // R2

  AST_RDATA_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:14] == 2'b00);  // R8
endmodule

bind tsi_cd_switch tsi_cd_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_ch    (out_ch),
  .reg_rdata (reg_rdata)
);

// File: tb/sim_tsi_cd_switch.sv
module sim_tsi_cd_switch;
  localparam int NIN = 4, NOUT = 4, LAST = 31, NCH = 32, MAXF = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid, out_sof;
  logic [4:0]  out_ch;
  logic [31:0] out_data;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  always #5 clk = ~clk;

  tsi_cd_switch u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
    .out_sof(out_sof), .out_ch(out_ch), .out_data(out_data),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Reference model state
  int          n_chk = 0, n_fail = 0;
  int          fn = -1, ch = 0;
  bit          started = 1'b0;
  logic [7:0]  hist [0:MAXF-1][0:NIN-1][0:NCH-1];
  logic [15:0] cmm  [0:NOUT-1][0:127];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int f, int s, int c);
    return 8'(f * 53 + s * 29 + c * 7 + 3);
  endfunction

  task automatic clear_in();
    in_valid = 1'b0; in_sof = 1'b0;
    reg_wr_en = 1'b0; reg_rd_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); clear_in();
    @(posedge clk); #1;
    chk("R2 no slot no output", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic cm_wr(input int o, input int c, input logic [15:0] val);
    @(negedge clk); clear_in();
    reg_wr_en = 1'b1; reg_addr = {2'(o), 7'(c)}; reg_wdata = val;
    if (c < NCH) cmm[o][c] = val & 16'h3FFF;  // R9: out of range ignored
    @(posedge clk); #1;
    chk("R2 no slot during write", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic cm_rd(input int o, input int c, input string tag);
    logic [15:0] exp;
    @(negedge clk); clear_in();
    reg_rd_en = 1'b1; reg_addr = {2'(o), 7'(c)};
    exp = (c < NCH) ? cmm[o][c] : 16'd0;
    @(posedge clk); #1;
    chk(tag, {16'd0, reg_rdata}, {16'd0, exp});
  endtask

  task automatic do_slot(input bit sof);
    bit          acc;
    logic [7:0]  expb [0:NOUT-1];
    string       tags [0:NOUT-1];
    logic [15:0] w;
    int          st, sc;
    @(negedge clk); clear_in();
    in_valid = 1'b1; in_sof = sof;
    acc = sof || started;
    if (acc) begin
      if (sof) begin fn++; ch = 0; end
      else ch = (ch + 1) % NCH;
      started = 1'b1;
    end
    for (int s = 0; s < NIN; s++) in_data[s*8 +: 8] = pat((fn < 0) ? 0 : fn, s, ch);
    if (acc) begin
      for (int o = 0; o < NOUT; o++) begin
        w = cmm[o][ch];
        st = int'(w[13:9]); sc = int'(w[8:1]);
        if (w[0]) begin
          expb[o] = w[10:3]; tags[o] = "R6 message byte";
        end else if (st >= NIN || sc > LAST) begin
          expb[o] = 8'd0; tags[o] = "R7 bad source gives zero";
        end else if (fn < 2) begin
          expb[o] = 8'd0; tags[o] = "R5 early frame zero";
        end else begin
          expb[o] = hist[fn-2][st][sc];
          if ((sc == LAST && ch == 0) || (sc == 0 && ch == LAST)) tags[o] = "R4 extreme delay";
          else if (o == 3 && ch == 3) tags[o] = "R8 bit14 ignored";
          else tags[o] = "R3 switched delay";
        end
        if (o == 2 && ch == 10 && fn == 5) tags[o] = "R10 new word at next slot";
      end
      if (fn < MAXF)
        for (int s = 0; s < NIN; s++) hist[fn][s][ch] = in_data[s*8 +: 8];
    end
    @(posedge clk); #1;
    chk("R2 out_valid", {31'd0, out_valid}, {31'd0, acc});
    if (acc) begin
      chk("R2 out_sof", {31'd0, out_sof}, {31'd0, sof});
      chk("R2 out_ch", {27'd0, out_ch}, 32'(ch));
      for (int o = 0; o < NOUT; o++)
        chk(tags[o], {24'd0, out_data[o*8 +: 8]}, {24'd0, expb[o]});
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int f = 0; f < MAXF; f++)
      for (int s = 0; s < NIN; s++)
        for (int c = 0; c < NCH; c++) hist[f][s][c] = 8'd0;
    for (int o = 0; o < NOUT; o++)
      for (int c = 0; c < 128; c++) cmm[o][c] = 16'd0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 out_data in reset", out_data, 32'd0);
    chk("R1 rdata in reset", {16'd0, reg_rdata}, 32'd0);
    chk("R1 in_ready in reset", {31'd0, in_ready}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2 in_ready after reset", {31'd0, in_ready}, 32'd1);
    cm_rd(0, 0, "R1 word zero");
    cm_rd(3, 31, "R1 word zero");

    // Connection programming
    cm_wr(0, 0, 16'((3 << 9) | (31 << 1)));          // R4 shortest
    cm_wr(0, 8, 16'hFFFF);                           // R8 top bits dropped
    cm_wr(0, 40, 16'h1234);                          // R9 out of range
    for (int c = 0; c < LAST; c++)
      cm_wr(1, c, 16'(((c % 4) << 9) | ((LAST - c) << 1)));
    cm_wr(1, LAST, 16'h0000);                        // R4 longest
    for (int c = 0; c < NCH; c++)
      if (c != 5) cm_wr(2, c, 16'((2 << 9) | (c << 1)));
    cm_wr(2, 5, 16'(1 | (8'hA5 << 3)));              // R6
    cm_wr(3, 2, 16'((7 << 9) | (4 << 1)));           // R7 stream
    cm_wr(3, 3, 16'(16'h4000 | (1 << 9) | (3 << 1))); // R8 bit14
    cm_wr(3, 4, 16'((1 << 9) | (50 << 1)));          // R7 channel
    cm_wr(3, 10, 16'((3 << 9) | (31 << 1)));

    cm_rd(0, 40, "R9 out of range reads zero");
    cm_rd(0, 8, "R8 readback");
    cm_rd(3, 3, "R8 readback bit14 clear");
    cm_rd(2, 5, "R8 readback");
    cm_rd(1, 17, "R8 readback");

    // R2: slots before first frame start are dropped
    do_slot(1'b0); do_slot(1'b0); do_slot(1'b0);
    idle();

    for (int f = 0; f < 8; f++) begin
      for (int c = 0; c < NCH; c++) begin
        if (f == 5 && c == 10) cm_wr(2, 10, 16'(1 | (8'h3C << 3)));  // R10
        do_slot(c == 0);
        if (c % 5 == 4) idle();
      end
    end
    cm_rd(2, 10, "R10 readback");
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule